// File: doc/BRIEF.md
# Triple-Redundant Result Voter with Disagreement Code

This block takes three 64-bit result words from identical, redundant processing branches. When a valid strobe is high it registers two things. The first is the bit-by-bit majority of the three words. The second is a 3-bit code that says how the branches compared: all agree, exactly one named branch is the outlier, or no two branches match. With a single faulty branch the registered word still carries the correct value, so the fault is masked, and the code says where it came from.

Both registered outputs hold between strobes, so the result of the last comparison stays readable. Two further outputs sit beside them. One is a saturating tally of comparisons that found any disagreement. The other is a sticky indication that at least one comparison had no majority at all. A test harness uses these to sort the faults the block detected from faults that were masked silently.

Top module: `tmr_vote_cmp`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, `voted`, `status`, `err_count` and `no_majority` all become 0.
- R2: On a rising edge with `res_valid` high, `voted` takes the bitwise majority of `br_a`, `br_b` and `br_c`. Each output bit is 1 when at least two of the three input bits are 1.
- R3: On a rising edge with `res_valid` high and all three inputs identical, `status` becomes 0.
- R4: On a rising edge with `res_valid` high and exactly one input different from the other two, `status` names that input. It becomes 1 for `br_a`, 2 for `br_b` and 3 for `br_c`.
- R5: On a rising edge with `res_valid` high and all three inputs pairwise different, `status` becomes 4.
- R6: `status` never takes the values 5, 6 or 7.
- R7: On a rising edge with `res_valid` low, `voted` and `status` keep their values, whatever the inputs carry.
- R8: `err_count` rises by exactly 1 on each rising edge with `res_valid` high where the new status is not 0. Otherwise it holds. It saturates at 65535.
- R9: `no_majority` becomes 1 on a rising edge with `res_valid` high where the new status is 4. It then stays 1 until reset.
- R10: When two inputs are equal and a valid comparison is made, `voted` equals the value of those two inputs, whatever the third input carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| res_valid | input | 1 | Strobe: compare and capture the three inputs on this edge |
| br_a | input | 64 | Result word of branch 1 |
| br_b | input | 64 | Result word of branch 2 |
| br_c | input | 64 | Result word of branch 3 |
| voted | output | 64 | Registered bitwise majority word |
| status | output | 3 | Registered comparison code (0, 1, 2, 3 or 4) |
| err_count | output | 16 | Saturating count of valid comparisons with non-zero code |
| no_majority | output | 1 | Sticky: a comparison with code 4 has occurred |

## Verification
Two functions can act on the same edge. A comparison that yields code 4 also advances the error tally and sets the sticky no-majority flag. A comparison made while the tally is already at its ceiling must update the code but leave the count unchanged. The first case is provoked with directed and random all-different triples. The second is provoked by holding a single-outlier pattern valid for more than 65535 cycles and then applying an all-different triple. In each case the bench compares all four outputs against a model that is updated only on valid edges.

// File: rtl/tmr_pkg.sv
// Package: shared status encoding for the triple-redundant voter.
// Assumes: the 3-bit code is decoded downstream by value, so the values are fixed.
package tmr_pkg;
    localparam int STAT_W = 3;

    typedef enum logic [STAT_W-1:0] {
        ST_AGREE    = 3'd0,
        ST_ODD_A    = 3'd1,
        ST_ODD_B    = 3'd2,
        ST_ODD_C    = 3'd3,
        ST_ALL_DIFF = 3'd4
    } tmr_status_e;
endpackage

// File: rtl/tmr_bit_majority.sv
// Module: combinational two-of-three majority over W bits.
// Assumes: inputs are settled in the same cycle; no registers here.
module tmr_bit_majority #(
    parameter int W = 64
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic [W-1:0] maj
);
    // One voting cell per bit position
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign maj[i] = (in_a[i] & in_b[i]) | (in_a[i] & in_c[i]) | (in_b[i] & in_c[i]);
    end
endmodule

// File: rtl/tmr_classify.sv
// Module: combinational classifier naming the outlier branch of three.
// Assumes: whole words are compared; a single differing bit makes a word differ.
module tmr_classify
    import tmr_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output tmr_status_e  code
);
    logic eq_ab, eq_bc, eq_ac;

    assign eq_ab = (in_a == in_b);
    assign eq_bc = (in_b == in_c);
    assign eq_ac = (in_a == in_c);

    // Map the three pair equalities onto the status code
    always_comb begin
        if (eq_ab && eq_bc)      code = ST_AGREE;
        else if (eq_bc)          code = ST_ODD_A;
        else if (eq_ac)          code = ST_ODD_B;
        else if (eq_ab)          code = ST_ODD_C;
        else                     code = ST_ALL_DIFF;
    end
endmodule

// File: rtl/tmr_err_tally.sv
// Module: saturating disagreement counter plus sticky no-majority flag.
// Assumes: upd is high only on edges where a fresh code is being captured.
module tmr_err_tally
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  tmr_status_e      code,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Count valid comparisons that found any disagreement, stopping at the ceiling
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (upd && code != ST_AGREE && count != CNT_MAX)
            count <= count + 1'b1;
    end

    // Remember that a comparison without any majority has been seen
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (upd && code == ST_ALL_DIFF)
            flag <= 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (count == $past(count) || count == $past(count) + 1'b1)); // R8
    AST_CNT_HOLD_ON_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd || code == ST_AGREE) |=> $stable(count)); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> flag); // R9
endmodule

// File: rtl/tmr_vote_cmp.sv
// Module: top of the triple-redundant voter; registers the vote and the status code.
// Assumes: the three branch words are aligned to the same res_valid strobe.
module tmr_vote_cmp
    import tmr_pkg::*;
#(
    parameter int W     = 64,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [W-1:0]     br_a,
    input  logic [W-1:0]     br_b,
    input  logic [W-1:0]     br_c,
    output logic [W-1:0]     voted,
    output logic [STAT_W-1:0] status,
    output logic [CNT_W-1:0] err_count,
    output logic             no_majority
);
    logic [W-1:0] maj_w;
    tmr_status_e  code_w;

    tmr_bit_majority #(.W(W)) u_maj (
        .in_a (br_a),
        .in_b (br_b),
        .in_c (br_c),
        .maj  (maj_w)
    );

    tmr_classify #(.W(W)) u_cls (
        .in_a (br_a),
        .in_b (br_b),
        .in_c (br_c),
        .code (code_w)
    );

    tmr_err_tally #(.CNT_W(CNT_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (res_valid),
        .code  (code_w),
        .count (err_count),
        .flag  (no_majority)
    );

    // Capture vote and code on the strobe, hold them between strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            voted  <= '0;
            status <= ST_AGREE;
        end else if (res_valid) begin
            voted  <= maj_w;
            status <= code_w;
        end
    end

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        status <= 3'd4); // R6
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> ($stable(status) && $stable(voted))); // R7
    AST_PAIR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && br_a == br_c) |=> voted == $past(br_a)); // R10
    AST_AGREE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && br_a == br_b && br_b == br_c) |=> status == 3'd0); // R3
    AST_ALL_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && br_a != br_b && br_b != br_c && br_a != br_c) |=> status == 3'd4); // R5
endmodule

// File: tb/tb_tmr_vote_cmp.sv
`timescale 1ns/1ps
module tb_tmr_vote_cmp;
    localparam int W = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          res_valid = 1'b0;
    logic [W-1:0]  br_a = '0, br_b = '0, br_c = '0;
    logic [W-1:0]  voted;
    logic [2:0]    status;
    logic [15:0]   err_count;
    logic          no_majority;

    int n_run = 0;
    int n_fail = 0;

    logic [W-1:0] m_vote = '0;
    logic [2:0]   m_stat = '0;
    int           m_cnt = 0;
    logic         m_flag = 1'b0;

    always #4 clk = ~clk;

    tmr_vote_cmp dut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid),
        .br_a(br_a), .br_b(br_b), .br_c(br_c),
        .voted(voted), .status(status), .err_count(err_count), .no_majority(no_majority)
    );

    function automatic logic [W-1:0] f_vote(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = (int'(a[i]) + int'(b[i]) + int'(c[i])) >= 2;
        return r;
    endfunction

    function automatic logic [2:0] f_code(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        if (a == b && b == c) return 3'd0;
        if (b == c) return 3'd1;
        if (a == c) return 3'd2;
        if (a == b) return 3'd3;
        return 3'd4;
    endfunction

    function automatic logic [W-1:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [W-1:0] rnd_nz();
        logic [W-1:0] m = {$urandom, $urandom};
        if (m == '0) m = 64'd1;
        return m;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(string tag);
        chk({tag, " voted"}, voted, m_vote);
        chk({tag, " status"}, {61'd0, status}, {61'd0, m_stat});
        chk({tag, " err_count"}, {48'd0, err_count}, 64'(m_cnt));
        chk({tag, " no_majority"}, {63'd0, no_majority}, {63'd0, m_flag});
        chk("R6 legal code", {63'd0, status > 3'd4}, 64'd0);
    endtask

    // Drive one cycle at the falling edge, update the model, sample after the rising edge
    task automatic step(logic v, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        @(negedge clk);
        res_valid = v; br_a = a; br_b = b; br_c = c;
        @(posedge clk);
        if (v) begin
            m_vote = f_vote(a, b, c);
            m_stat = f_code(a, b, c);
            if (m_stat != 3'd0 && m_cnt < 65535) m_cnt++;
            if (m_stat == 3'd4) m_flag = 1'b1;
        end
        #2;
    endtask

    initial begin
        #(200000 * 8);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] base, m1, m2;
        void'($urandom(32'd20240517));
        br_a = rnd64(); br_b = rnd64(); br_c = rnd64(); res_valid = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        chk_all("R1 reset");
        @(negedge clk); rst_n = 1'b1; res_valid = 1'b0;

        base = 64'hDEAD_BEEF_0123_4567;
        step(1, base, base, base);           chk_all("R3 agree");
        step(1, base ^ 64'h1, base, base);   chk_all("R4 odd A / R10");
        step(1, base, base ^ 64'h80, base);  chk_all("R4 odd B / R10");
        step(1, base, base, ~base);          chk_all("R4 odd C / R10");
        chk("R9 flag clear before code 4", {63'd0, no_majority}, 64'd0);
        step(1, 64'h00FF, 64'h0F0F, 64'h3333); chk_all("R5 all differ / R2");
        step(1, base, base, base);           chk_all("R9 flag sticky / R8 hold");
        step(0, 64'h1, 64'h2, 64'h4);        chk_all("R7 hold on invalid");
        step(0, ~base, base, 64'h0);         chk_all("R7 hold on invalid 2");

        for (int k = 0; k < 400; k++) begin
            int sel = int'($urandom % 6);
            base = rnd64(); m1 = rnd_nz(); m2 = rnd_nz();
            if (m2 == m1) m2 = m1 ^ 64'h8000_0000_0000_0000;
            case (sel)
                0: step(1, base, base, base);
                1: step(1, base ^ m1, base, base);
                2: step(1, base, base ^ m1, base);
                3: step(1, base, base, base ^ m1);
                4: step(1, base, base ^ m1, base ^ m2);
                default: step($urandom % 2 == 0, rnd64(), rnd64(), rnd64());
            endcase
            chk_all("R2 R3 R4 R5 R7 R8 random");
        end

        // Saturation: hold a single-outlier pattern valid past the counter ceiling
        @(negedge clk);
        res_valid = 1'b1; br_a = 64'h5; br_b = 64'h5; br_c = 64'h7;
        for (int k = 0; k < 65600; k++) begin
            @(posedge clk);
            if (m_cnt < 65535) m_cnt++;
        end
        m_vote = 64'h5; m_stat = 3'd3;
        #2;
        chk_all("R8 saturate");
        step(1, 64'h1, 64'h2, 64'h4);        chk_all("R8 saturated code 4 / R9");
        chk("R8 ceiling", {48'd0, err_count}, 64'd65535);

        rst_n = 1'b0;
        @(posedge clk); #2;
        m_vote = '0; m_stat = '0; m_cnt = 0; m_flag = 1'b0;
        chk_all("R1 reset again");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule